// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Interface

This block holds the configuration that a clock synthesizer's dividers run from: a 9-bit feedback divider value M, a 2-bit output divider code N and a 2-bit test selector T. New values arrive on one of two paths. The first is a set of parallel pins gated by an active-low parallel strobe. The second is a three-wire serial port made of a data line, a clock and a load strobe. The block drives the active M and N values to the dividers. It also drives a TEST pin whose source is picked by T.

Everything runs on one fast system clock. The serial clock, the serial data, the serial load strobe and the parallel strobe each pass through a two-flop synchronizer, and the block acts on the edges it finds after that. For this to work the system clock must be at least four times the serial clock rate. The block also registers a flag when M leaves the range the loop can lock at. It gives a one-cycle pulse whenever the active M or N value changes, so the dividers downstream can restart cleanly.

Top module: `synth_cfg_ctrl`

## Requirements
- R1: When reset is released, M reads 20 and N reads 01. T is 00, so TEST is low. Both `m_invalid` and `cfg_update` are low.
- R2: A serial frame is 14 bits, most significant first, in this order: T1, T0, a null bit, N1, N0, then M8 down to M0. M0 is the last bit shifted. The null bit is discarded.
- R3: While the parallel strobe is high and the serial load strobe is low, rising serial-clock edges shift the data in and leave M and N unchanged.
- R4: A rising edge of the serial load strobe copies the shift register into M, N and T. After the strobe falls, later shifting does not change them.
- R5: While the serial load strobe stays high, every rising serial-clock edge shifts one bit and passes the new shift contents straight to M and N.
- R6: While the parallel strobe is low, the parallel M and N pins drive M and N. The value latched at the strobe's rising edge holds until the strobe goes low again or a serial load occurs.
- R7: TEST follows T1:T0: 00 gives low, 01 gives the serial data input, 10 gives the feedback clock and 11 gives the divided clock. While the parallel strobe is low, TEST is low whatever T holds.
- R8: `m_invalid` is high exactly when the active M is below 8 or above 28.
- R9: `cfg_update` pulses for one cycle when M or N changes, including one pulse when both change together. There is no pulse when a load writes the values already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset, loads defaults |
| par_load_n | input | 1 | Parallel strobe: pins pass through while low, latched on rise |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 2 | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe |
| fb_clk | input | 1 | Feedback divider output, TEST source 10 |
| div_clk | input | 1 | Divided output clock, TEST source 11 |
| m_val | output | 9 | Active feedback divider value |
| n_code | output | 2 | Active output divider code |
| test_o | output | 1 | Test output |
| m_invalid | output | 1 | Active M is outside 8..28 |
| cfg_update | output | 1 | One-cycle pulse when M or N changes |

## Verification
Shifting and transfer fall in the same cycle when the serial load strobe is held high. Every serial-clock rise then both moves the shift register and rewrites M and N (R5). The bench holds the strobe high across a full frame and keeps its own 14-bit model of the shift register. After each bit it compares M and N with the model. The same model supplies the values expected after the later load events. A load that changes M and N in the same cycle must give exactly one `cfg_update` pulse, which the bench counts at the ports.

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl #(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int M_DEF = 20,
  parameter int N_DEF = 1,
  parameter int M_LO  = 8,
  parameter int M_HI  = 28,
  parameter int SYNC  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_load,
  input  logic           fb_clk,
  input  logic           div_clk,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic           test_o,
  output logic           m_invalid,
  output logic           cfg_update
);
  localparam int FRAME_W = 3 + N_W + M_W;
  localparam logic [M_W-1:0] M_RST = M_W'(M_DEF);
  localparam logic [N_W-1:0] N_RST = N_W'(N_DEF);
  localparam logic INV_RST = (M_DEF < M_LO) || (M_DEF > M_HI);

  logic [SYNC:0]   sclk_q, sld_q, pld_q;
  logic [SYNC-1:0] dat_q;
  logic            sclk_rise, sld_rise, sld_s, pld_s, dat_s;
  logic [FRAME_W-1:0] sr, sr_nxt;
  logic [1:0]      t_reg, t_nxt;
  logic [M_W-1:0]  m_nxt;
  logic [N_W-1:0]  n_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      sld_q  <= '0;
      pld_q  <= '1;
      dat_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC-1:0], ser_clk};
      sld_q  <= {sld_q[SYNC-1:0], ser_load};
      pld_q  <= {pld_q[SYNC-1:0], par_load_n};
      dat_q  <= {dat_q[SYNC-2:0], ser_dat};
    end
  end

  assign sclk_rise = sclk_q[SYNC-1] & ~sclk_q[SYNC];
  assign sld_s     = sld_q[SYNC-1];
  assign sld_rise  = sld_s & ~sld_q[SYNC];
  assign pld_s     = pld_q[SYNC-1];
  assign dat_s     = dat_q[SYNC-1];

  assign sr_nxt = (sclk_rise && pld_s) ? {sr[FRAME_W-2:0], dat_s} : sr;

  always_comb begin
    m_nxt = m_val;
    n_nxt = n_code;
    t_nxt = t_reg;
    if (!pld_s) begin
      m_nxt = par_m;
      n_nxt = par_n;
    end else if (sld_s && (sld_rise || sclk_rise)) begin
      m_nxt = sr_nxt[M_W-1:0];
      n_nxt = sr_nxt[M_W+N_W-1:M_W];
      t_nxt = sr_nxt[FRAME_W-1:FRAME_W-2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      m_val      <= M_RST;
      n_code     <= N_RST;
      t_reg      <= 2'b00;
      m_invalid  <= INV_RST;
      cfg_update <= 1'b0;
    end else begin
      sr         <= sr_nxt;
      m_val      <= m_nxt;
      n_code     <= n_nxt;
      t_reg      <= t_nxt;
      m_invalid  <= (int'(m_nxt) < M_LO) || (int'(m_nxt) > M_HI);
      cfg_update <= (m_nxt != m_val) || (n_nxt != n_code);
    end
  end

  always_comb begin
    test_o = 1'b0;
    if (pld_s) begin
      case (t_reg)
        2'b01:   test_o = ser_dat;
        2'b10:   test_o = fb_clk;
        2'b11:   test_o = div_clk;
        default: test_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/synth_cfg_ctrl_chk.sv
module synth_cfg_ctrl_chk #(
  parameter int M_W  = 9,
  parameter int N_W  = 2,
  parameter int M_LO = 8,
  parameter int M_HI = 28
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pld_s,
  input logic           sld_s,
  input logic [M_W-1:0] par_m,
  input logic [M_W-1:0] m_val,
  input logic [N_W-1:0] n_code,
  input logic           test_o,
  input logic           m_invalid,
  input logic           cfg_update
);
  a_r3_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pld_s && !sld_s) |=> ($stable(m_val) && $stable(n_code)));

  a_r6_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !pld_s |=> (m_val == $past(par_m)));

  a_r7_par_test_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pld_s |-> !test_o);

  a_r8_range_flag: assert property (@(posedge clk) disable iff (!rst_n)
    m_invalid == ((int'(m_val) < M_LO) || (int'(m_val) > M_HI)));

  a_r9_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_update |-> ((m_val != $past(m_val)) || (n_code != $past(n_code))));
endmodule

bind synth_cfg_ctrl synth_cfg_ctrl_chk #(.M_W(M_W), .N_W(N_W), .M_LO(M_LO), .M_HI(M_HI)) chk (
  .clk(clk), .rst_n(rst_n), .pld_s(pld_s), .sld_s(sld_s), .par_m(par_m),
  .m_val(m_val), .n_code(n_code), .test_o(test_o), .m_invalid(m_invalid),
  .cfg_update(cfg_update));

// File: tb/sim_synth_cfg_ctrl.sv
`timescale 1ns/1ps
module sim_synth_cfg_ctrl;
  logic clk = 0, rst_n = 0;
  logic par_load_n = 1, ser_clk = 0, ser_dat = 0, ser_load = 0, fb_clk = 0, div_clk = 0;
  logic [8:0] par_m = 0;
  logic [1:0] par_n = 0;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic test_o, m_invalid, cfg_update;
  int tests = 0, fails = 0, upd_cnt = 0;
  logic [13:0] mdl = '0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_cfg_ctrl u0 (.clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m),
    .par_n(par_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load(ser_load),
    .fb_clk(fb_clk), .div_clk(div_clk), .m_val(m_val), .n_code(n_code),
    .test_o(test_o), .m_invalid(m_invalid), .cfg_update(cfg_update));

  always @(negedge clk) if (rst_n && cfg_update) upd_cnt++;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(logic b);
    ser_dat = b; wt(3);
    ser_clk = 1; wt(5);
    ser_clk = 0; wt(4);
    if (par_load_n) mdl = {mdl[12:0], b};
  endtask

  task automatic sframe(logic [1:0] t, logic nl, logic [1:0] n, logic [8:0] m);
    logic [13:0] f;
    f = {t, nl, n, m};
    for (int i = 13; i >= 0; i--) sbit(f[i]);
  endtask

  task automatic sload();
    ser_load = 1; wt(6);
    ser_load = 0; wt(6);
  endtask

  task automatic t_reset();
    chk("R1 m", m_val, 20);
    chk("R1 n", n_code, 1);
    chk("R1 test", test_o, 0);
    chk("R1 invalid", m_invalid, 0);
    chk("R1 update", cfg_update, 0);
  endtask

  task automatic t_serial();
    upd_cnt = 0;
    sframe(2'b01, 1'b1, 2'd2, 9'd25);
    chk("R3 m held while shifting", m_val, 20);
    chk("R3 n held while shifting", n_code, 1);
    chk("R3 no update pulse", upd_cnt, 0);
    sload();
    chk("R2 R4 m loaded", m_val, 25);
    chk("R2 R4 n loaded", n_code, 2);
    chk("R9 one pulse for M and N", upd_cnt, 1);
    ser_dat = 1; #1 chk("R7 T=01 data high", test_o, 1);
    ser_dat = 0; #1 chk("R7 T=01 data low", test_o, 0);
    sframe(2'b01, 1'b0, 2'd3, 9'd9);
    chk("R4 held after strobe fell", m_val, 25);
    sload();
    chk("R4 m second load", m_val, 9);
    chk("R4 n second load", n_code, 3);
    upd_cnt = 0;
    sload();
    chk("R9 no pulse on same value", upd_cnt, 0);
  endtask

  task automatic t_mux();
    sframe(2'b10, 1'b0, 2'd3, 9'd9); sload();
    fb_clk = 1; #1 chk("R7 T=10 fb high", test_o, 1);
    fb_clk = 0; #1 chk("R7 T=10 fb low", test_o, 0);
    sframe(2'b11, 1'b1, 2'd3, 9'd9); sload();
    div_clk = 1; #1 chk("R7 T=11 div high", test_o, 1);
    div_clk = 0; #1 chk("R7 T=11 div low", test_o, 0);
    sframe(2'b00, 1'b0, 2'd3, 9'd9); sload();
    fb_clk = 1; div_clk = 1; ser_dat = 1;
    #1 chk("R7 T=00 low", test_o, 0);
    fb_clk = 0; div_clk = 0; ser_dat = 0;
  endtask

  task automatic t_passthru();
    logic [13:0] f;
    f = {2'b11, 1'b0, 2'b01, 9'd28};
    ser_load = 1; wt(6);
    chk("R5 transfer on rise", m_val, int'(mdl[8:0]));
    for (int i = 13; i >= 0; i--) begin
      sbit(f[i]);
      chk("R5 m per bit", m_val, int'(mdl[8:0]));
      chk("R5 n per bit", n_code, int'(mdl[10:9]));
    end
    ser_load = 0; wt(6);
    chk("R5 final m", m_val, 28);
    chk("R8 M=28 valid", m_invalid, 0);
    div_clk = 1; #1 chk("R7 T=11 after pass-through", test_o, 1);
  endtask

  task automatic t_parallel();
    par_m = 7; par_n = 0; par_load_n = 0; wt(5);
    chk("R6 m follows pins", m_val, 7);
    chk("R8 M=7 invalid", m_invalid, 1);
    chk("R7 parallel forces low", test_o, 0);
    par_m = 8; wt(4);
    chk("R8 M=8 valid", m_invalid, 0);
    par_m = 29; wt(4);
    chk("R8 M=29 invalid", m_invalid, 1);
    par_m = 12; par_n = 2; wt(4);
    chk("R6 m follows pins again", m_val, 12);
    par_load_n = 1; wt(5);
    par_m = 17; par_n = 1; wt(5);
    chk("R6 m latched", m_val, 12);
    chk("R6 n latched", n_code, 2);
    div_clk = 0;
    sframe(2'b00, 1'b0, 2'd1, 9'd16); sload();
    chk("R6 serial load overrides", m_val, 16);
    chk("R6 serial n", n_code, 1);
  endtask

  initial begin
    wt(4); rst_n = 1; wt(2);
    t_reset();
    t_serial();
    t_mux();
    t_passthru();
    t_parallel();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule